// File: doc/BRIEF.md
# Execution Unit Power Gate Controller

This controller sits beside one execution pipeline (for example the integer lanes or the floating-point lanes of a shader core). It decides, cycle by cycle, when the lane group may have its supply cut and when the supply must come back. It watches two things: a per-cycle busy flag from the pipeline, and the number of active warps whose next instruction targets this unit type. From these it drives a sleep control, a wake control and an issue-ready flag for the scheduler.

Once the unit has gated, it is held off for a full breakeven interval even if instructions for it are waiting. This forced-idle window ensures that every gating event at least recovers its own switching energy. A wake request that lands in the last cycle of that window is flagged as a critical wakeup, which indicates that the window probably cost performance. The controller then spends a fixed number of cycles restoring power before it reports ready again. In coordinated mode gating is also held back while any warp of this type is still active. In free mode the warp count is ignored.

Top module: `pgate_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the state code is 0 (powered), `unit_ready` is 1, and `sleep_en`, `wake_en` and `crit_wake` are 0. Reset acts without waiting for a clock edge.
- R2: In the powered state, the unit gates when `unit_busy` has been low for N consecutive cycles. N is `cfg_idle` when nonzero and 5 when `cfg_idle` is 0. The state becomes 1 (blackout) on the clock edge that ends the Nth idle cycle. Any busy cycle restarts the count from zero.
- R3: With `cfg_coord` = 1, the unit never gates while `warp_cnt` is nonzero. It gates on the first idle cycle with `warp_cnt` = 0 in which the idle run has reached N. With `cfg_coord` = 0, `warp_cnt` has no effect.
- R4: The blackout state lasts exactly B cycles. During that time `wake_req` is ignored: `sleep_en` stays 1 and `unit_ready` stays 0.
- R5: B equals `cfg_bet`, limited to the range 9 to 24. A value below 9 gives 9 and a value above 24 gives 24.
- R6: If `wake_req` is high in the last blackout cycle, the next state is 3 (waking). `crit_wake` is then high for exactly one cycle, the first waking cycle.
- R7: If `wake_req` is low in the last blackout cycle, the next state is 2 (gated idle). From gated idle, `wake_req` moves the unit to waking on the next edge, and `crit_wake` stays 0.
- R8: The waking state lasts exactly 3 cycles, after which the state returns to 0 with a fresh idle count.
- R9: `unit_ready` is 1 only in state 0. `sleep_en` is 1 only in states 1 and 2. `wake_en` is 1 only in state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle | input | 4 | Idle cycles before gating (0 selects 5) |
| cfg_bet | input | 5 | Breakeven window length, limited to 9..24 |
| cfg_coord | input | 1 | 1: gate only when no warp of this type is active |
| unit_busy | input | 1 | Pipeline executed an instruction this cycle |
| warp_cnt | input | 6 | Active warps waiting for this unit type |
| wake_req | input | 1 | Instruction pending for this unit |
| sleep_en | output | 1 | Supply cut request |
| wake_en | output | 1 | Supply restore in progress |
| unit_ready | output | 1 | Unit may accept an issue |
| crit_wake | output | 1 | One-cycle critical wakeup pulse |
| pg_state | output | 2 | State code: 0 powered, 1 blackout, 2 gated idle, 3 waking |

## Verification
The bench uses the default parameters. These give a 4-bit idle setting and a 5-bit breakeven setting, so settings of 3 and 31 can be written and both ends of the breakeven limit can be reached. An idle setting of 0 reaches the default threshold of 5. The cycle table uses an idle threshold of 2 and the minimum window of 9. At that size a full gate, blackout, wake and re-gate sequence fits in a short table, and both the critical and the plain wakeup paths appear in it.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic [1:0] {
    PG_ON       = 2'd0,
    PG_BLACKOUT = 2'd1,
    PG_OFF      = 2'd2,
    PG_WAKE     = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgate_cfg_clamp.sv
// Maps raw configuration to effective thresholds.
module pgate_cfg_clamp #(
  parameter int IDLE_W   = 4,
  parameter int BET_W    = 5,
  parameter int IDLE_DEF = 5,
  parameter int BET_MIN  = 9,
  parameter int BET_MAX  = 24
) (
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [BET_W-1:0]  cfg_bet,
  output logic [IDLE_W-1:0] idle_thr,
  output logic [BET_W-1:0]  bet_len
);
  localparam logic [IDLE_W-1:0] IDLE_DEF_V = IDLE_W'(IDLE_DEF);
  localparam logic [BET_W-1:0]  BET_MIN_V  = BET_W'(BET_MIN);
  localparam logic [BET_W-1:0]  BET_MAX_V  = BET_W'(BET_MAX);

  always_comb begin
    if (cfg_idle == '0) idle_thr = IDLE_DEF_V;
    else                idle_thr = cfg_idle;
  end

  always_comb begin
    if (cfg_bet < BET_MIN_V)      bet_len = BET_MIN_V;
    else if (cfg_bet > BET_MAX_V) bet_len = BET_MAX_V;
    else                          bet_len = cfg_bet;
  end
endmodule

// File: rtl/pgate_idle_mon.sv
// Counts consecutive idle cycles while powered; saturates.
module pgate_idle_mon #(
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              busy,
  input  logic [IDLE_W-1:0] thr,
  output logic              thr_met
);
  localparam logic [IDLE_W-1:0] CNT_MAX = '1;

  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic [IDLE_W:0]   run;

  assign run     = {1'b0, cnt_q} + (IDLE_W+1)'(1);
  assign thr_met = !busy && (run >= {1'b0, thr});

  always_comb begin
    cnt_en = clr || busy || (cnt_q != CNT_MAX);
    if (clr || busy) cnt_d = '0;
    else             cnt_d = cnt_q + IDLE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgate_win_tmr.sv
// Down counter shared by the blackout and wakeup windows.
module pgate_win_tmr #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = load || (run && !done);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int IDLE_W   = 4,
  parameter int BET_W    = 5,
  parameter int WARP_W   = 6,
  parameter int IDLE_DEF = 5,
  parameter int BET_MIN  = 9,
  parameter int BET_MAX  = 24,
  parameter int WAKE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [BET_W-1:0]  cfg_bet,
  input  logic              cfg_coord,
  input  logic              unit_busy,
  input  logic [WARP_W-1:0] warp_cnt,
  input  logic              wake_req,
  output logic              sleep_en,
  output logic              wake_en,
  output logic              unit_ready,
  output logic              crit_wake,
  output logic [1:0]        pg_state
);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);
  localparam int TMR_W  = (BET_W > WAKE_W) ? BET_W : WAKE_W;
  localparam logic [TMR_W-1:0] WAKE_LOAD = TMR_W'(WAKE_CYC - 1);

  pg_state_e         st_q, st_d;
  logic              crit_q, crit_d;
  logic [IDLE_W-1:0] idle_thr;
  logic [BET_W-1:0]  bet_len;
  logic              thr_met, gate_ok;
  logic              tmr_load, tmr_run, tmr_done;
  logic [TMR_W-1:0]  tmr_val;

  pgate_cfg_clamp #(
    .IDLE_W(IDLE_W), .BET_W(BET_W), .IDLE_DEF(IDLE_DEF),
    .BET_MIN(BET_MIN), .BET_MAX(BET_MAX)
  ) u_clamp (
    .cfg_idle(cfg_idle), .cfg_bet(cfg_bet),
    .idle_thr(idle_thr), .bet_len(bet_len)
  );

  pgate_idle_mon #(.IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(st_q != PG_ON),
    .busy(unit_busy), .thr(idle_thr), .thr_met(thr_met)
  );

  pgate_win_tmr #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .done(tmr_done)
  );

  assign gate_ok = thr_met && (!cfg_coord || (warp_cnt == '0));
  assign tmr_run = (st_q == PG_BLACKOUT) || (st_q == PG_WAKE);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    crit_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      PG_ON: begin
        if (gate_ok) begin
          st_d     = PG_BLACKOUT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(bet_len) - TMR_W'(1);
        end
      end
      PG_BLACKOUT: begin
        if (tmr_done) begin
          if (wake_req) begin
            st_d     = PG_WAKE;
            crit_d   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = WAKE_LOAD;
          end else begin
            st_d = PG_OFF;
          end
        end
      end
      PG_OFF: begin
        if (wake_req) begin
          st_d     = PG_WAKE;
          tmr_load = 1'b1;
          tmr_val  = WAKE_LOAD;
        end
      end
      PG_WAKE: begin
        if (tmr_done) st_d = PG_ON;
      end
      default: st_d = PG_ON;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_ON;
      crit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      crit_q <= crit_d;
    end
  end

  assign unit_ready = (st_q == PG_ON);
  assign sleep_en   = (st_q == PG_BLACKOUT) || (st_q == PG_OFF);
  assign wake_en    = (st_q == PG_WAKE);
  assign crit_wake  = crit_q;
  assign pg_state   = st_q;
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
  parameter int IDLE_W  = 4,
  parameter int BET_W   = 5,
  parameter int WARP_W  = 6,
  parameter int BET_MIN = 9,
  parameter int BET_MAX = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BET_W-1:0]  cfg_bet,
  input logic              cfg_coord,
  input logic              unit_busy,
  input logic [WARP_W-1:0] warp_cnt,
  input logic              wake_req,
  input logic              unit_ready,
  input logic              sleep_en,
  input logic              crit_wake,
  input logic [1:0]        pg_state
);
  logic [5:0] blk_len_q;
  int         bet_eff;

  always_comb begin
    if (int'(cfg_bet) < BET_MIN)      bet_eff = BET_MIN;
    else if (int'(cfg_bet) > BET_MAX) bet_eff = BET_MAX;
    else                              bet_eff = int'(cfg_bet);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       blk_len_q <= '0;
    else if (pg_state != 2'd1)                        blk_len_q <= '0;
    else if (blk_len_q != 6'h3f)                      blk_len_q <= blk_len_q + 6'd1;
  end

  AST_GATE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_state == 2'd1 && $past(pg_state) == 2'd0) |-> $past(!unit_busy)); // R2

  AST_COORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_state == 2'd0 && cfg_coord && warp_cnt != '0) |=> pg_state == 2'd0); // R3

  AST_BLACKOUT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pg_state) == 2'd1 && pg_state != 2'd1) |-> int'(blk_len_q) == bet_eff); // R4

  AST_BLACKOUT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_state == 2'd1 && wake_req) |-> (sleep_en && !unit_ready)); // R4

  AST_CRIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    crit_wake |=> !crit_wake); // R6

  AST_CRIT_FROM_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    crit_wake |-> ($past(pg_state) == 2'd1 && pg_state == 2'd3)); // R6

  AST_OFF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_state == 2'd2 && wake_req) |=> (pg_state == 2'd3 && !crit_wake)); // R7
endmodule

bind pgate_ctrl pgate_ctrl_chk #(
  .IDLE_W(IDLE_W), .BET_W(BET_W), .WARP_W(WARP_W),
  .BET_MIN(BET_MIN), .BET_MAX(BET_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bet(cfg_bet), .cfg_coord(cfg_coord),
  .unit_busy(unit_busy), .warp_cnt(warp_cnt), .wake_req(wake_req),
  .unit_ready(unit_ready), .sleep_en(sleep_en), .crit_wake(crit_wake),
  .pg_state(pg_state)
);

// File: tb/test_pgate_ctrl.sv
module test_pgate_ctrl;
  logic       clk;
  logic       rst_n;
  logic [3:0] cfg_idle;
  logic [4:0] cfg_bet;
  logic       cfg_coord;
  logic       unit_busy;
  logic [5:0] warp_cnt;
  logic       wake_req;
  logic       sleep_en, wake_en, unit_ready, crit_wake;
  logic [1:0] pg_state;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  pgate_ctrl i_pgate_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .cfg_bet(cfg_bet),
    .cfg_coord(cfg_coord), .unit_busy(unit_busy), .warp_cnt(warp_cnt),
    .wake_req(wake_req), .sleep_en(sleep_en), .wake_en(wake_en),
    .unit_ready(unit_ready), .crit_wake(crit_wake), .pg_state(pg_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {busy, warp_nonzero, wake_req, exp_crit, exp_state[1:0]}; idle 2, window 9, coordinated
  localparam logic [5:0] VEC [34] = '{
    6'b100000, 6'b000000, 6'b100000, 6'b000000, 6'b010000, 6'b000001,
    6'b001001, 6'b001001, 6'b001001, 6'b001001,
    6'b001001, 6'b001001, 6'b001001, 6'b001001,
    6'b001111, 6'b000011, 6'b000011, 6'b100000, 6'b000000, 6'b000001,
    6'b000001, 6'b000001, 6'b000001, 6'b000001,
    6'b000001, 6'b000001, 6'b000001, 6'b000001,
    6'b000010, 6'b000010, 6'b001011, 6'b000011, 6'b000011, 6'b000000
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R9 ready"}, int'(unit_ready), int'(pg_state == 2'd0));
    chk({tag, " R9 sleep"}, int'(sleep_en), int'(pg_state == 2'd1 || pg_state == 2'd2));
    chk({tag, " R9 wake_en"}, int'(wake_en), int'(pg_state == 2'd3));
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_idle = 4'd2; cfg_bet = 5'd9; cfg_coord = 1'b1;
    unit_busy = 1'b0; warp_cnt = '0; wake_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 state in reset", int'(pg_state), 0);
    chk("R1 ready in reset", int'(unit_ready), 1);
    chk("R1 sleep in reset", int'(sleep_en), 0);
    chk("R1 crit in reset", int'(crit_wake), 0);
    rst_n = 1'b1;
    step();
    chk("R1 state after reset", int'(pg_state), 0);
    chk("R1 wake_en after reset", int'(wake_en), 0);

    // table: R2 R3 R4 R6 R7 R8 cycle by cycle
    foreach (VEC[i]) begin
      unit_busy = VEC[i][5];
      warp_cnt  = VEC[i][4] ? 6'd5 : 6'd0;
      wake_req  = VEC[i][3];
      step();
      chk($sformatf("R2 R3 R4 R7 R8 table state v%0d", i), int'(pg_state), int'(VEC[i][1:0]));
      chk($sformatf("R6 table crit v%0d", i), int'(crit_wake), int'(VEC[i][2]));
      chk_outs("table");
    end

    // R2 default threshold, R3 free mode ignores warps, R5 low limit, R7 plain wake
    cfg_idle = 4'd0; cfg_coord = 1'b0; cfg_bet = 5'd3; warp_cnt = 6'd5;
    unit_busy = 1'b1; wake_req = 1'b0;
    step();
    unit_busy = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk($sformatf("R2 R3 default idle step %0d", k), int'(pg_state), (k == 5) ? 1 : 0);
    end
    n = 1;
    for (int k = 0; k < 40; k++) begin
      step();
      if (pg_state != 2'd1) break;
      n++;
    end
    chk("R5 low limit window", n, 9);
    chk("R7 gated idle after window", int'(pg_state), 2);
    chk_outs("R7 gated idle");
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R7 plain wake state", int'(pg_state), 3);
    chk("R7 plain wake not critical", int'(crit_wake), 0);
    step(); chk("R8 waking 2", int'(pg_state), 3);
    step(); chk("R8 waking 3", int'(pg_state), 3);
    step(); chk("R8 powered after wake", int'(pg_state), 0);

    // R5 high limit, R6 critical wake with request held through blackout
    cfg_idle = 4'd1; cfg_bet = 5'd31; warp_cnt = '0;
    unit_busy = 1'b1;
    step();
    chk("R2 busy keeps powered", int'(pg_state), 0);
    unit_busy = 1'b0;
    step();
    chk("R2 idle one gates", int'(pg_state), 1);
    wake_req = 1'b1;
    n = 1;
    for (int k = 0; k < 40; k++) begin
      step();
      if (pg_state != 2'd1) break;
      n++;
      chk("R4 ready low in blackout", int'(unit_ready), 0);
    end
    chk("R5 high limit window", n, 24);
    chk("R6 critical state", int'(pg_state), 3);
    chk("R6 critical pulse", int'(crit_wake), 1);
    wake_req = 1'b0;
    step();
    chk("R6 pulse one cycle", int'(crit_wake), 0);
    step();
    step();
    chk("R8 powered after critical wake", int'(pg_state), 0);

    // R2 busy restarts the idle run, threshold 3
    cfg_idle = 4'd3; cfg_bet = 5'd9;
    unit_busy = 1'b0; step(); chk("R2 run 1", int'(pg_state), 0);
    unit_busy = 1'b0; step(); chk("R2 run 2", int'(pg_state), 0);
    unit_busy = 1'b1; step(); chk("R2 busy restart", int'(pg_state), 0);
    unit_busy = 1'b0; step(); chk("R2 rerun 1", int'(pg_state), 0);
    unit_busy = 1'b0; step(); chk("R2 rerun 2", int'(pg_state), 0);
    unit_busy = 1'b0; step(); chk("R2 rerun 3 gates", int'(pg_state), 1);

    // R1 asynchronous reset in blackout
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset state", int'(pg_state), 0);
    chk("R1 async reset ready", int'(unit_ready), 1);
    chk("R1 async reset sleep", int'(sleep_en), 0);
    report();
  end
endmodule